// File: doc/BRIEF.md
# Hot-Plug Slot Command Completion Unit

This block holds the slot control word of a hot-plug capable downstream port and the completion flag that goes with it. Software updates the control word with masked 16-bit writes. Each write is sorted by its effect. Bits that only enable notifications are applied in the next cycle. The four fields that an external slot controller has to carry out are passed to that controller over a request/acknowledge pair. Those fields are the interlock control, the power controller control, the power indicator and the attention indicator. The control word takes the new field values when the acknowledge arrives, and the completion flag is raised in the same update.

A mode input widens completion reporting so that every control write raises the flag. A capability input removes completion reporting altogether. While a command is outstanding, later control writes are merged into one holding slot. That slot is replayed once the acknowledge arrives, so no write is lost. The completion flag is cleared by writing 1 to it. A level interrupt follows the flag while both interrupt enables are set.

Top module: `slotcmd_top`

## Requirements
- R1: After reset the control word, the completion flag, the request and the interrupt are all 0.
- R2: A control write (wrEn=1, wrSel=0) sets each bit where wrMask is 1 to wrData and keeps every other bit. Bits outside the external field set 0x0FC0 show the new value in the next cycle and raise no completion.
- R3: A control write that changes any bit of the external field set raises slotReq in the next cycle. The field set is bit 11 (interlock), bit 10 (power controller), bits 9:8 (power indicator) and bits 7:6 (attention indicator). reqFields carries the new values of those fields. The fields in slotCtrl keep their old value until the acknowledge.
- R4: When slotAck is sampled high while slotReq is high, the requested fields are written into slotCtrl, slotReq drops and cmdCmplSts becomes 1, all in the next cycle.
- R5: With allWriteMode=0, a control write that leaves all external fields unchanged raises no request and no completion.
- R6: With allWriteMode=1, every control write raises a completion. A write that changes no external field sets cmdCmplSts in the next cycle, without a request.
- R7: While noCmplCap=1, cmdCmplSts is never set. Requests and field updates still take place.
- R8: irq is 1 exactly while cmdCmplSts is 1 and control bits 4 (completion interrupt enable) and 5 (hot-plug interrupt enable) are both 1.
- R9: A status write (wrEn=1, wrSel=1) clears cmdCmplSts when wrData[4] and wrMask[4] are both 1. Writing a 0 to bit 4 leaves the flag unchanged.
- R10: Control writes that arrive while a request is outstanding are merged in arrival order and leave slotCtrl untouched. They are applied in the cycle after the acknowledge and may start a new request.
- R11: If a completion and a clearing status write fall in the same cycle, the flag ends up 1.
- R12: slotAck is ignored while no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | 0 selects the control word, 1 selects status |
| wrData | input | 16 | Write data |
| wrMask | input | 16 | Per-bit write enable |
| allWriteMode | input | 1 | Every control write raises a completion |
| noCmplCap | input | 1 | Suppresses completion reporting |
| slotReq | output | 1 | Request to the external slot controller, high while busy |
| slotAck | input | 1 | Acknowledge from the slot controller |
| reqFields | output | 16 | Requested values of the external fields |
| slotCtrl | output | 16 | Current control word |
| cmdCmplSts | output | 1 | Command completed flag |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can act in the same cycle. One is the completion that the acknowledge sets. The other is the write-one clear of the flag. To provoke the collision, the bench drives the acknowledge and a clearing status write on the same clock edge, after first clearing the flag so that only the set path can leave it at 1. A second overlap, held writes replayed right behind an acknowledge, is judged through the control word and the second request.

// File: rtl/slotcmd_pkg.sv
package slotcmd_pkg;
  localparam int unsigned CW = 16;
  localparam logic [CW-1:0] EXT_FIELDS = 16'h0FC0;
  localparam int unsigned CMPL_BIT = 4;
  localparam int unsigned CCIE_BIT = 4;
  localparam int unsigned HPIE_BIT = 5;

  typedef struct packed {
    logic useHold;
    logic apply;
    logic commit;
    logic setCmpl;
    logic holdLoad;
    logic holdMerge;
  } strobe_t;
endpackage

// File: rtl/slotcmd_ctrl.sv
module slotcmd_ctrl
  import slotcmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctrlWr,
  input  logic    extDiff,
  input  logic    ack,
  input  logic    allMode,
  output strobe_t st,
  output logic    busy
);
  logic holdValid;
  logic proc;

  always_comb begin
    proc         = !busy && (holdValid || ctrlWr);
    st.useHold   = holdValid;
    st.apply     = proc;
    st.commit    = busy && ack;
    st.setCmpl   = (busy && ack) || (proc && !extDiff && allMode);
    st.holdLoad  = ctrlWr && (holdValid ? proc : busy);
    st.holdMerge = ctrlWr && holdValid && !proc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      holdValid <= 1'b0;
    end else begin
      busy      <= busy ? !ack : (proc && extDiff);
      holdValid <= (holdValid && !proc) || (ctrlWr && (busy || holdValid));
    end
  end

  // R4: an acknowledge ends the outstanding command
  p_ack_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy && ack |=> !busy);
  // R10: request stays up until acknowledged
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && !ack |=> busy);
endmodule

// File: rtl/slotcmd_dp.sv
module slotcmd_dp
  import slotcmd_pkg::*;
#(
  parameter int unsigned W = CW,
  parameter logic [W-1:0] EXT = EXT_FIELDS
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      st,
  input  logic [W-1:0] inData,
  input  logic [W-1:0] inMask,
  input  logic         stsClr,
  input  logic         noCap,
  output logic         extDiff,
  output logic [W-1:0] ctrlReg,
  output logic [W-1:0] pendExt,
  output logic         cmplSts,
  output logic         irq
);
  logic [W-1:0] holdData, holdMask, srcData, srcMask, cand;

  always_comb begin
    srcData = st.useHold ? holdData : inData;
    srcMask = st.useHold ? holdMask : inMask;
    cand    = (ctrlReg & ~srcMask) | (srcData & srcMask);
    extDiff = |((cand ^ ctrlReg) & EXT);
    irq     = cmplSts && ctrlReg[CCIE_BIT] && ctrlReg[HPIE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      pendExt  <= '0;
      holdData <= '0;
      holdMask <= '0;
      cmplSts  <= 1'b0;
    end else begin
      if (st.commit)
        ctrlReg <= (ctrlReg & ~EXT) | pendExt;
      else if (st.apply) begin
        ctrlReg <= (ctrlReg & EXT) | (cand & ~EXT);
        pendExt <= cand & EXT;
      end
      if (st.holdLoad) begin
        holdData <= inData;
        holdMask <= inMask;
      end else if (st.holdMerge) begin
        holdData <= (holdData & ~inMask) | (inData & inMask);
        holdMask <= holdMask | inMask;
      end
      if (st.setCmpl && !noCap) cmplSts <= 1'b1;
      else if (stsClr)          cmplSts <= 1'b0;
    end
  end

  // R3: external fields move only on a commit
  p_ext_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(ctrlReg & EXT));
  // R7: no completion while the capability is absent
  p_nocap_r7: assert property (@(posedge clk) disable iff (!rstN)
    noCap && !cmplSts |=> !cmplSts);
  // R11: a completion event is never lost to a clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.setCmpl && !noCap |=> cmplSts);
endmodule

// File: rtl/slotcmd_top.sv
module slotcmd_top
  import slotcmd_pkg::*;
#(
  parameter int unsigned W = CW
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] wrMask,
  input  logic         allWriteMode,
  input  logic         noCmplCap,
  output logic         slotReq,
  input  logic         slotAck,
  output logic [W-1:0] reqFields,
  output logic [W-1:0] slotCtrl,
  output logic         cmdCmplSts,
  output logic         irq
);
  strobe_t st;
  logic    extDiff, busy, ctrlWr, stsClr;

  assign ctrlWr  = wrEn && !wrSel;
  assign stsClr  = wrEn && wrSel && wrData[CMPL_BIT] && wrMask[CMPL_BIT];
  assign slotReq = busy;

  slotcmd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .extDiff(extDiff),
    .ack(slotAck), .allMode(allWriteMode), .st(st), .busy(busy)
  );

  slotcmd_dp #(.W(W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .inData(wrData), .inMask(wrMask),
    .stsClr(stsClr), .noCap(noCmplCap), .extDiff(extDiff),
    .ctrlReg(slotCtrl), .pendExt(reqFields), .cmplSts(cmdCmplSts), .irq(irq)
  );
endmodule

// File: tb/tb_slotcmd_top.sv
module tb_slotcmd_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [15:0] wrData = '0, wrMask = '0;
  logic        allWriteMode = 1'b0, noCmplCap = 1'b0, slotAck = 1'b0;
  logic        slotReq, cmdCmplSts, irq;
  logic [15:0] reqFields, slotCtrl;
  int          nChk = 0, nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slotcmd_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wrMask(wrMask), .allWriteMode(allWriteMode), .noCmplCap(noCmplCap),
    .slotReq(slotReq), .slotAck(slotAck), .reqFields(reqFields),
    .slotCtrl(slotCtrl), .cmdCmplSts(cmdCmplSts), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // one write, inputs driven at a falling edge; returns after the next falling edge
  task automatic wr(input logic sel, input logic [15:0] d, input logic [15:0] m);
    wrEn = 1'b1; wrSel = sel; wrData = d; wrMask = m;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0; wrMask = '0;
  endtask

  task automatic doAck(input int delay);
    repeat (delay) @(negedge clk);
    slotAck = 1'b1;
    @(negedge clk);
    slotAck = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 ctrl", slotCtrl, 16'h0000);
    chk("R1 sts", {15'b0, cmdCmplSts}, 16'h0);
    chk("R1 req", {15'b0, slotReq}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic tEnables();
    wr(1'b0, 16'h1030, 16'hFFFF);
    chk("R2 ctrl full", slotCtrl, 16'h1030);
    chk("R2 no sts", {15'b0, cmdCmplSts}, 16'h0);
    chk("R2 no req", {15'b0, slotReq}, 16'h0);
    wr(1'b0, 16'h0000, 16'h0010);
    chk("R2 ctrl masked", slotCtrl, 16'h1020);
  endtask

  task automatic tCommand();
    wr(1'b0, 16'h0440, 16'h0FC0);
    chk("R3 req", {15'b0, slotReq}, 16'h1);
    chk("R3 fields", reqFields, 16'h0440);
    chk("R3 ctrl waits", slotCtrl, 16'h1020);
    chk("R3 no sts yet", {15'b0, cmdCmplSts}, 16'h0);
    doAck(3);
    chk("R4 req drop", {15'b0, slotReq}, 16'h0);
    chk("R4 ctrl", slotCtrl, 16'h1460);
    chk("R4 sts", {15'b0, cmdCmplSts}, 16'h1);
    chk("R8 irq off", {15'b0, irq}, 16'h0);
  endtask

  task automatic tClear();
    wr(1'b1, 16'h0000, 16'hFFFF);
    chk("R9 zero keeps", {15'b0, cmdCmplSts}, 16'h1);
    wr(1'b1, 16'h0010, 16'h0010);
    chk("R9 clear", {15'b0, cmdCmplSts}, 16'h0);
  endtask

  task automatic tSame();
    wr(1'b0, 16'h0440, 16'h0FC0);
    @(negedge clk);
    chk("R5 no req", {15'b0, slotReq}, 16'h0);
    chk("R5 no sts", {15'b0, cmdCmplSts}, 16'h0);
  endtask

  task automatic tIrq();
    wr(1'b0, 16'h0030, 16'h0030);
    chk("R8 ctrl", slotCtrl, 16'h1470);
    wr(1'b0, 16'h0000, 16'h0400);
    chk("R3 fields2", reqFields, 16'h0040);
    doAck(1);
    chk("R4 ctrl2", slotCtrl, 16'h1070);
    chk("R8 irq on", {15'b0, irq}, 16'h1);
    wr(1'b1, 16'h0010, 16'h0010);
    chk("R8 irq clr", {15'b0, irq}, 16'h0);
  endtask

  task automatic tAllMode();
    allWriteMode = 1'b1;
    wr(1'b0, 16'h0000, 16'h0000);
    chk("R6 sts", {15'b0, cmdCmplSts}, 16'h1);
    chk("R6 no req", {15'b0, slotReq}, 16'h0);
    chk("R8 irq mode", {15'b0, irq}, 16'h1);
    wr(1'b0, 16'h0000, 16'h0020);
    chk("R8 hpie off", {15'b0, irq}, 16'h0);
    chk("R6 ctrl", slotCtrl, 16'h1050);
    wr(1'b1, 16'h0010, 16'h0010);
    allWriteMode = 1'b0;
  endtask

  task automatic tNoCap();
    noCmplCap = 1'b1;
    wr(1'b0, 16'h0100, 16'h0300);
    chk("R7 req", {15'b0, slotReq}, 16'h1);
    chk("R7 fields", reqFields, 16'h0140);
    doAck(2);
    chk("R7 ctrl", slotCtrl, 16'h1150);
    chk("R7 no sts", {15'b0, cmdCmplSts}, 16'h0);
    noCmplCap = 1'b0;
  endtask

  task automatic tHeldAndRace();
    wr(1'b0, 16'h0800, 16'h0800);
    chk("R10 fields", reqFields, 16'h0940);
    wr(1'b0, 16'h0000, 16'h0100);
    wr(1'b0, 16'h0000, 16'h0010);
    chk("R10 ctrl untouched", slotCtrl, 16'h1150);
    doAck(1);
    chk("R10 first done", slotCtrl, 16'h1950);
    chk("R10 gap req", {15'b0, slotReq}, 16'h0);
    @(negedge clk);
    chk("R10 replay req", {15'b0, slotReq}, 16'h1);
    chk("R10 replay fields", reqFields, 16'h0840);
    chk("R10 replay ctrl", slotCtrl, 16'h1940);
    wr(1'b1, 16'h0010, 16'h0010);
    chk("R11 pre clear", {15'b0, cmdCmplSts}, 16'h0);
    slotAck = 1'b1;
    wr(1'b1, 16'h0010, 16'h0010);
    slotAck = 1'b0;
    chk("R11 set wins", {15'b0, cmdCmplSts}, 16'h1);
    chk("R11 ctrl", slotCtrl, 16'h1840);
    wr(1'b1, 16'h0010, 16'h0010);
  endtask

  task automatic tIdleAck();
    doAck(0);
    @(negedge clk);
    chk("R12 req", {15'b0, slotReq}, 16'h0);
    chk("R12 sts", {15'b0, cmdCmplSts}, 16'h0);
    chk("R12 ctrl", slotCtrl, 16'h1840);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEnables();
    tCommand();
    tClear();
    tSame();
    tIrq();
    tAllMode();
    tNoCap();
    tHeldAndRace();
    tIdleAck();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end
endmodule